// File: doc/BRIEF.md
# Colour Lookup Table with Byte-Wide Host Port

This block holds a 256-entry colour lookup table. Each entry has a 6-bit red, green and blue field. A host reaches the table through four byte-wide registers, chosen by a 2-bit select: a write cursor, a read cursor, a shared colour data port and a pixel mask. The host writes a cursor once. It then streams red, green and blue bytes through the data port, and the cursor moves to the next entry after every third byte.

The display pipeline drives an 8-bit pixel index on a separate port. Each cycle, the block ANDs that index with the mask and returns the selected triple one clock later. Host traffic does not stall or disturb this lookup.

The read and write paths each keep their own cursor and their own colour phase. Read and write sequences can therefore interleave freely. A write sequence holds red and green aside and commits all three fields together on the blue byte, so the pixel side never sees a half-updated entry.

Top module: `pal_host_lut`

## Requirements
- R1: After reset both cursors are 0, both colour phases are at red, the pixel mask is 0xFF, every entry is zero and the pixel outputs are zero.
- R2: A host write with select 0 loads the write cursor and restarts the write phase at red; a host read with select 0 returns the current write cursor, including after automatic advances.
- R3: Three host writes with select 2 supply red, green and blue of the write-cursor entry, in that order; the entry changes only when the blue byte is written, and the first two bytes are held aside until then.
- R4: A host write with select 1 loads the read cursor and restarts the read phase at red; three host reads with select 2 return red, green and blue of the read-cursor entry in that order; a read with select 1 returns the read cursor.
- R5: After every third data access on a path, that path's cursor increments by one, and from 255 it wraps to 0.
- R6: Only bits 5:0 of a written colour byte are kept; colour reads return the stored field in bits 5:0 with bits 7:6 zero.
- R7: A host write with select 3 sets the pixel mask, which is readable with select 3; the pixel index is ANDed with the mask before lookup, so 0xFF leaves it unchanged.
- R8: The pixel outputs show the entry addressed by the masked index one clock after the index is presented; if the host commits that same entry in the same cycle, the old value appears first and the new one on the following cycle.
- R9: Read and write phases are independent: data reads interleaved with a data write sequence neither move the write phase nor are moved by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select: 0 write cursor, 1 read cursor, 2 colour data, 3 pixel mask |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe; a data read advances the read phase |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte of the selected register, combinational |
| pix_index | input | 8 | Pixel index from the display pipeline |
| pix_red | output | 6 | Red field of the looked-up entry, registered |
| pix_green | output | 6 | Green field of the looked-up entry, registered |
| pix_blue | output | 6 | Blue field of the looked-up entry, registered |

## Verification
The bench aims at the cursor wrap from 255 to 0 on both paths. A design that dropped the carry or used a 257-state count would report a wrong cursor there.

It interleaves data reads with a three-byte write sequence. A shared or cross-coupled phase counter would return colours out of order or store bytes into the wrong field.

It probes the pixel side in two situations: after only two data writes, where a design committing byte by byte would show a partly updated entry, and in the cycle the blue byte commits, where a forwarding or late-read design would show the new colour one cycle early. The mask check presents an index with high bits set, so a design that ignored the mask would fetch an empty entry.

// File: rtl/pal_pkg.sv
package pal_pkg;

    parameter int IDX_W   = 8;
    parameter int COLOR_W = 6;
    parameter int BYTE_W  = 8;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int PAD_W   = BYTE_W - COLOR_W;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
    } rgb_t;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEL_WCUR = 2'd0,
        SEL_RCUR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_MASK = 2'd3
    } sel_e;

    function automatic logic [BYTE_W-1:0] pick_field(input rgb_t c, input phase_e ph);
        logic [COLOR_W-1:0] f;
        case (ph)
            PH_RED:   f = c.red;
            PH_GREEN: f = c.green;
            default:  f = c.blue;
        endcase
        return {{PAD_W{1'b0}}, f};
    endfunction

endpackage

// File: rtl/pal_cursor.sv
module pal_cursor
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output phase_e           phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            phase <= PH_RED;
        end else if (load) begin
            idx   <= load_idx;
            phase <= PH_RED;
        end else if (step) begin
            case (phase)
                PH_RED:   phase <= PH_GREEN;
                PH_GREEN: phase <= PH_BLUE;
                default: begin
                    phase <= PH_RED;
                    idx   <= idx + 1'b1;
                end
            endcase
        end
    end

    assert_cursor_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (phase == PH_RED) && (idx == $past(load_idx)));

    assert_cursor_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !load && phase == PH_BLUE) |=> (idx == IDX_W'($past(idx) + 1'b1)) && (phase == PH_RED));

    assert_cursor_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(idx) && $stable(phase));

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  rgb_t             wdata,
    input  logic [IDX_W-1:0] raddr,
    output rgb_t             rdata,
    input  logic [IDX_W-1:0] paddr,
    output rgb_t             pdata
);

    rgb_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
            pdata <= '0;
        end else begin
            if (we) mem[waddr] <= wdata;
            pdata <= mem[paddr];
        end
    end

    assign rdata = mem[raddr];

    assert_store_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == raddr) |=> (rdata == $past(wdata)) || (raddr != $past(raddr)));

endmodule

// File: rtl/pal_host_lut.sv
module pal_host_lut
    import pal_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   host_sel,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [7:0]   host_wdata,
    output logic [7:0]   host_rdata,
    input  logic [7:0]   pix_index,
    output logic [5:0]   pix_red,
    output logic [5:0]   pix_green,
    output logic [5:0]   pix_blue
);

    logic wr_wcur, wr_rcur, wr_data, wr_mask, rd_data;
    logic [IDX_W-1:0] wcur_idx, rcur_idx;
    phase_e           wcur_ph, rcur_ph;
    logic [IDX_W-1:0] pix_mask;
    logic [COLOR_W-1:0] hold_red, hold_green;
    logic             commit;
    rgb_t             commit_rgb, host_entry, pix_entry;

    assign wr_wcur = host_wr && (host_sel == SEL_WCUR);
    assign wr_rcur = host_wr && (host_sel == SEL_RCUR);
    assign wr_data = host_wr && (host_sel == SEL_DATA);
    assign wr_mask = host_wr && (host_sel == SEL_MASK);
    assign rd_data = host_rd && (host_sel == SEL_DATA);

    pal_cursor u_wcur (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_wcur),
        .load_idx (host_wdata[IDX_W-1:0]),
        .step     (wr_data),
        .idx      (wcur_idx),
        .phase    (wcur_ph)
    );

    pal_cursor u_rcur (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_rcur),
        .load_idx (host_wdata[IDX_W-1:0]),
        .step     (rd_data),
        .idx      (rcur_idx),
        .phase    (rcur_ph)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_red   <= '0;
            hold_green <= '0;
            pix_mask   <= '1;
        end else begin
            if (wr_data && wcur_ph == PH_RED)   hold_red   <= host_wdata[COLOR_W-1:0];
            if (wr_data && wcur_ph == PH_GREEN) hold_green <= host_wdata[COLOR_W-1:0];
            if (wr_mask) pix_mask <= host_wdata[IDX_W-1:0];
        end
    end

    assign commit           = wr_data && (wcur_ph == PH_BLUE);
    assign commit_rgb.red   = hold_red;
    assign commit_rgb.green = hold_green;
    assign commit_rgb.blue  = host_wdata[COLOR_W-1:0];

    pal_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .waddr (wcur_idx),
        .wdata (commit_rgb),
        .raddr (rcur_idx),
        .rdata (host_entry),
        .paddr (pix_index & pix_mask),
        .pdata (pix_entry)
    );

    always_comb begin
        case (host_sel)
            SEL_WCUR: host_rdata = wcur_idx;
            SEL_RCUR: host_rdata = rcur_idx;
            SEL_DATA: host_rdata = pick_field(host_entry, rcur_ph);
            default:  host_rdata = pix_mask;
        endcase
    end

    assign pix_red   = pix_entry.red;
    assign pix_green = pix_entry.green;
    assign pix_blue  = pix_entry.blue;

    assert_color_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
        rd_data |-> host_rdata[7:6] == 2'b00);

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> pix_mask == $past(host_wdata));

    assert_wphase_untouched_by_reads_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !host_wr) |=> $stable(wcur_ph) && $stable(wcur_idx));

endmodule

// File: tb/test_pal_host_lut.sv
module test_pal_host_lut;

    localparam int CLK_NS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_sel = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] pix_index = '0;
    logic [5:0] pix_red, pix_green, pix_blue;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pal_host_lut i_pal_host_lut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .pix_index(pix_index),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic       wr;
        logic       rd;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 1'b0, 8'h05, 1'b0, 8'h00, 4'd2}, // R2 write cursor 5
        '{2'd2, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, 4'd3}, // R3 red, R6 top bits dropped
        '{2'd2, 1'b1, 1'b0, 8'h12, 1'b0, 8'h00, 4'd3}, // R3 green
        '{2'd2, 1'b1, 1'b0, 8'hC7, 1'b0, 8'h00, 4'd3}, // R3 blue -> commit
        '{2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h06, 4'd5}, // R5 write cursor advanced
        '{2'd1, 1'b1, 1'b0, 8'h05, 1'b0, 8'h00, 4'd4}, // R4 read cursor 5
        '{2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h3F, 4'd6}, // R6 red 0x3F
        '{2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h12, 4'd4}, // R4 green
        '{2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h07, 4'd6}, // R6 blue 0x07
        '{2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h06, 4'd5}, // R5 read cursor advanced
        '{2'd0, 1'b1, 1'b0, 8'h09, 1'b0, 8'h00, 4'd9}, // R9 write cursor 9
        '{2'd2, 1'b1, 1'b0, 8'h01, 1'b0, 8'h00, 4'd9}, // R9 red
        '{2'd1, 1'b1, 1'b0, 8'h05, 1'b0, 8'h00, 4'd9}, // R9 read cursor 5
        '{2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h3F, 4'd9}, // R9 read red
        '{2'd2, 1'b1, 1'b0, 8'h02, 1'b0, 8'h00, 4'd9}, // R9 green
        '{2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h12, 4'd9}, // R9 read green
        '{2'd2, 1'b1, 1'b0, 8'h03, 1'b0, 8'h00, 4'd9}, // R9 blue
        '{2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h07, 4'd9}, // R9 read blue
        '{2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h0A, 4'd9}, // R9 write cursor 10
        '{2'd1, 1'b1, 1'b0, 8'h09, 1'b0, 8'h00, 4'd4}, // R4 read cursor 9
        '{2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h01, 4'd9}, // R9 entry 9 red
        '{2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h02, 4'd9}, // R9 entry 9 green
        '{2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h03, 4'd9}, // R9 entry 9 blue
        '{2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h0A, 4'd4}  // R4 read cursor 10
    };

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_pix(input logic [17:0] exp, input string tag);
        n_checks++;
        if ({pix_red, pix_green, pix_blue} !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %05h expected %05h", tag, {pix_red, pix_green, pix_blue}, exp);
        end
    endtask

    task automatic op(input logic [1:0] sel, input logic wr, input logic rd,
                      input logic [7:0] wd, input logic chk, input logic [7:0] exp,
                      input string tag);
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = wd;
        #1;
        if (chk) check8(host_rdata, exp, tag);
        @(posedge clk);
        #1;
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        op(2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00, "R1 write cursor");
        op(2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00, "R1 read cursor");
        op(2'd3, 1'b0, 1'b1, 8'h00, 1'b1, 8'hFF, "R1 pixel mask");
        op(2'd2, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, "R1 entry 0 red");
        check_pix(18'h0, "R1 pixel outputs");

        foreach (VECS[i]) begin
            op(VECS[i].sel, VECS[i].wr, VECS[i].rd, VECS[i].wd, VECS[i].chk, VECS[i].exp,
               $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R5 write wrap 255 -> 0
        op(2'd0, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, "R5");
        op(2'd2, 1'b1, 1'b0, 8'h11, 1'b0, 8'h00, "R5");
        op(2'd2, 1'b1, 1'b0, 8'h22, 1'b0, 8'h00, "R5");
        op(2'd2, 1'b1, 1'b0, 8'h33, 1'b0, 8'h00, "R5");
        op(2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00, "R5 write cursor wrap");
        // R5 read wrap 255 -> 0
        op(2'd1, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, "R5");
        op(2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h11, "R5 entry 255 red");
        op(2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h22, "R5 entry 255 green");
        op(2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h33, "R5 entry 255 blue");
        op(2'd1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00, "R5 read cursor wrap");

        // R7 mask: entry 5 = {3F,12,07}
        @(negedge clk); pix_index = 8'hF5;
        @(negedge clk); check_pix({6'h3F, 6'h12, 6'h07} & 18'h0, "R7 unmasked F5 is empty");
        op(2'd3, 1'b1, 1'b0, 8'h0F, 1'b0, 8'h00, "R7");
        op(2'd3, 1'b0, 1'b1, 8'h00, 1'b1, 8'h0F, "R7 mask readback");
        @(negedge clk); check_pix({6'h3F, 6'h12, 6'h07}, "R7 masked F5 hits entry 5");
        op(2'd3, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, "R7");

        // R3 partial write invisible, R8 same-cycle commit
        @(negedge clk); pix_index = 8'd20;
        op(2'd0, 1'b1, 1'b0, 8'd20, 1'b0, 8'h00, "R3");
        op(2'd2, 1'b1, 1'b0, 8'h2A, 1'b0, 8'h00, "R3");
        op(2'd2, 1'b1, 1'b0, 8'h15, 1'b0, 8'h00, "R3");
        @(negedge clk); check_pix(18'h0, "R3 entry unchanged after two bytes");
        host_sel = 2'd2; host_wr = 1'b1; host_wdata = 8'h0C;
        @(posedge clk); #1; host_wr = 1'b0;
        @(negedge clk); check_pix(18'h0, "R8 old value in commit cycle");
        @(negedge clk); check_pix({6'h2A, 6'h15, 6'h0C}, "R8 new value next cycle");

        // R8 latency: change index, output follows one edge later
        @(negedge clk); pix_index = 8'd5;
        #1; check_pix({6'h2A, 6'h15, 6'h0C}, "R8 output not yet updated");
        @(negedge clk); check_pix({6'h3F, 6'h12, 6'h07}, "R8 one-cycle lookup");

        // R2 reload write cursor mid-sequence restarts at red
        op(2'd0, 1'b1, 1'b0, 8'd30, 1'b0, 8'h00, "R2");
        op(2'd2, 1'b1, 1'b0, 8'h3E, 1'b0, 8'h00, "R2");
        op(2'd0, 1'b1, 1'b0, 8'd31, 1'b0, 8'h00, "R2");
        op(2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 8'd31, "R2 cursor reload readback");
        op(2'd2, 1'b1, 1'b0, 8'h04, 1'b0, 8'h00, "R2");
        op(2'd2, 1'b1, 1'b0, 8'h05, 1'b0, 8'h00, "R2");
        op(2'd2, 1'b1, 1'b0, 8'h06, 1'b0, 8'h00, "R2");
        op(2'd1, 1'b1, 1'b0, 8'd31, 1'b0, 8'h00, "R2");
        op(2'd2, 1'b0, 1'b1, 8'h00, 1'b1, 8'h04, "R2 red after restart");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule